// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is a single DMA channel that works through a circular list of 16-byte descriptors in memory. Each descriptor names a source address, a destination address and a byte count. The channel reads the descriptor, copies the data one 32-bit word at a time over a shared word-wide memory port, and then marks the entry finished by rewriting its first word with the valid flag cleared. After each entry it steps a next-entry pointer by 16 bytes, and that pointer returns to the ring base after the final slot.

Software drives the channel through a small 32-bit register file, addressed by word index. Index 0 is control/status, 1 is ring base (low half), 2 is ring base (high half, stored only), 3 is ring size in entries, 4 is the next-entry pointer, and 5 is the read-only address of the most recently fetched entry. When the channel reaches an entry that software has not filled yet, it stops there and raises a sticky flag. Writing a 1 to that flag makes the channel fetch the same slot again. The channel can also pause between descriptors, or abort and restart from a pointer that software has rewritten.

Top module: `dring_dma`

## Requirements
- R1: After reset, control/status (index 0), the next pointer (index 4) and the last-entry register (index 5) all read 0, and the memory port is idle.
- R2: A descriptor is four little-endian words at the entry address. The word at +0 holds valid in bit 31, interrupt-enable in bit 30 and the byte count in bits 26:0. The word at +4 holds the upper address bits, which are ignored. The word at +8 is the destination address and the word at +12 is the source address. The channel copies ceil(count/4) words from source to destination in ascending order, and every memory address it issues is word aligned.
- R3: When write-back enable (control bit 2) is 1, a finished entry's word at +0 is rewritten with bit 31 cleared and all other bits unchanged. When bit 2 is 0, the entry is left untouched in memory.
- R4: After each finished entry, the next pointer advances by 16. When it has just passed the entry at base + 16*(size-1), it returns to base.
- R5: Fetching an entry whose bit 31 is 0 sets descriptor-invalid (status bit 8), leaves the next pointer where it is, and halts the channel. Clearing bit 8 makes the channel fetch that same entry again.
- R6: An entry with byte count 0 moves no data. It is still written back, and the next pointer still advances.
- R7: done_irq pulses high for exactly one cycle when an entry with bit 30 set finishes, and stays low for entries without bit 30. The pulse appears 7 + 2*W cycles after the clock edge that sets start on an idle channel, where W is the number of words copied.
- R8: A control write with abort (bit 1) set to 1 and start (bit 3) set to 0 stops the channel within one cycle and sets abort-done (bit 10). The stopped entry is not written back, the next pointer does not move, and index 5 holds the address of the entry that was active.
- R9: While the channel is stopped, software may rewrite the next pointer. Setting start with abort clear then resumes fetching from the new address.
- R10: While pause (bit 0) is 1, the channel fetches nothing at a descriptor boundary and sets pause-done (bit 9). Clearing pause lets it continue.
- R11: Status bits 8, 9 and 10 are write-1-to-clear, and a clear takes precedence over a set in the same cycle. The channel fetches only while start is 1, abort is 0 and mode (bits 6:5) equals 2.
- R12: In-progress (bit 30) is 1 only from the first descriptor read until the write-back cycle, and every busy period begins with a descriptor read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_sel | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address, always word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| done_irq | output | 1 | One-cycle completion pulse for entries with interrupt-enable set |

## Verification
Register reads return one cycle after the strobe, so the bench samples reg_rdata on the falling edge after it drops the strobe. A descriptor takes one idle cycle, five fetch cycles, two cycles per copied word and one write-back cycle. For that reason the bench counts falling edges from the start write to the done_irq pulse and compares the count with 7 + 2*W. Every other memory or register check waits a fixed margin well beyond that length. By then the channel has parked on the following invalid entry, so the state it reports is stable when the bench samples it.

// File: rtl/dring_pkg.sv
package dring_pkg;

  // Register word indices
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] SEL_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] SEL_BASE_LO = 3'd1;
  localparam logic [REG_AW-1:0] SEL_BASE_HI = 3'd2;
  localparam logic [REG_AW-1:0] SEL_SIZE    = 3'd3;
  localparam logic [REG_AW-1:0] SEL_NEXT    = 3'd4;
  localparam logic [REG_AW-1:0] SEL_LAST    = 3'd5;

  // Control/status bit positions
  localparam int B_PAUSE = 0;
  localparam int B_ABORT = 1;
  localparam int B_WBEN  = 2;
  localparam int B_START = 3;
  localparam int B_MODE  = 5;
  localparam int B_INV   = 8;
  localparam int B_PDONE = 9;
  localparam int B_ADONE = 10;
  localparam int B_BUSY  = 30;
  localparam logic [1:0] MODE_RING = 2'd2;

  // Descriptor word 0 fields
  localparam int D_VALID = 31;
  localparam int D_IRQ   = 30;
  localparam int CNT_W   = 27;
  localparam int ENTRY_SHIFT = 4;

  typedef struct packed {
    logic [1:0] mode;
    logic       start;
    logic       wb_en;
    logic       abort;
    logic       pause;
  } ctrl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_F0, ST_F1, ST_F2, ST_F3, ST_F4, ST_RD, ST_WR, ST_WB
  } eng_state_t;

endpackage

// File: rtl/dring_ptr.sv
module dring_ptr
  import dring_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RING_W = 16
) (
  input  logic [AW-1:0]     base,
  input  logic [RING_W-1:0] ring_size,
  input  logic [AW-1:0]     cur,
  output logic [AW-1:0]     nxt
);
  localparam logic [AW-1:0] STEP = AW'(1 << ENTRY_SHIFT);

  logic [RING_W-1:0] slots_m1;
  logic [AW-1:0]     last_slot;

  // A ring size of 0 behaves as a single-entry ring
  assign slots_m1  = (ring_size == '0) ? '0 : ring_size - RING_W'(1);
  assign last_slot = base + (AW'(slots_m1) << ENTRY_SHIFT);
  assign nxt       = (cur == last_slot) ? base : cur + STEP;
endmodule

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic [AW-1:0]     last_desc,
  input  logic              set_inv,
  input  logic              set_pdone,
  input  logic              adv,
  input  logic [AW-1:0]     nxt_adv,
  output ctrl_t             ctrl,
  output logic              inv_flag,
  output logic [AW-1:0]     base,
  output logic [AW-1:0]     next_ptr,
  output logic [RING_W-1:0] ring_size
);
  logic        pdone, adone;
  logic [31:0] base_hi;
  logic        wr_ctrl, clr_inv, clr_pdone, clr_adone, abort_evt;
  logic [31:0] status_word;
  logic [31:0] rd_mux;

  assign wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL);
  assign clr_inv   = wr_ctrl && reg_wdata[B_INV];
  assign clr_pdone = wr_ctrl && reg_wdata[B_PDONE];
  assign clr_adone = wr_ctrl && reg_wdata[B_ADONE];
  assign abort_evt = wr_ctrl && reg_wdata[B_ABORT] && !reg_wdata[B_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      inv_flag  <= 1'b0;
      pdone     <= 1'b0;
      adone     <= 1'b0;
      base      <= '0;
      base_hi   <= '0;
      ring_size <= '0;
      next_ptr  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.pause <= reg_wdata[B_PAUSE];
        ctrl.abort <= reg_wdata[B_ABORT];
        ctrl.wb_en <= reg_wdata[B_WBEN];
        ctrl.start <= reg_wdata[B_START];
        ctrl.mode  <= reg_wdata[B_MODE+1:B_MODE];
      end
      // Sticky status: a software clear wins over a same-cycle set
      inv_flag <= (inv_flag | set_inv)   & ~clr_inv;
      pdone    <= (pdone    | set_pdone) & ~clr_pdone;
      adone    <= (adone    | abort_evt) & ~clr_adone;
      if (reg_wr && reg_sel == SEL_BASE_LO) base      <= reg_wdata[AW-1:0];
      if (reg_wr && reg_sel == SEL_BASE_HI) base_hi   <= reg_wdata;
      if (reg_wr && reg_sel == SEL_SIZE)    ring_size <= reg_wdata[RING_W-1:0];
      if (reg_wr && reg_sel == SEL_NEXT)    next_ptr  <= reg_wdata[AW-1:0];
      else if (adv)                         next_ptr  <= nxt_adv;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[B_PAUSE] = ctrl.pause;
    status_word[B_ABORT] = ctrl.abort;
    status_word[B_WBEN]  = ctrl.wb_en;
    status_word[B_START] = ctrl.start;
    status_word[B_MODE+1:B_MODE] = ctrl.mode;
    status_word[B_INV]   = inv_flag;
    status_word[B_PDONE] = pdone;
    status_word[B_ADONE] = adone;
    status_word[B_BUSY]  = busy;
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL:    rd_mux = status_word;
      SEL_BASE_LO: rd_mux = 32'(base);
      SEL_BASE_HI: rd_mux = base_hi;
      SEL_SIZE:    rd_mux = 32'(ring_size);
      SEL_NEXT:    rd_mux = 32'(next_ptr);
      SEL_LAST:    rd_mux = 32'(last_desc);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/dring_engine.sv
module dring_engine
  import dring_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          pause,
  input  logic          wb_en,
  input  logic          inv_flag,
  input  logic [AW-1:0] next_ptr,
  input  logic [31:0]   mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          busy,
  output logic [AW-1:0] last_desc,
  output logic          set_inv,
  output logic          set_pdone,
  output logic          adv,
  output logic          done_irq
);
  localparam logic [AW-1:0]    WORD_STEP = AW'(4);
  localparam logic [CNT_W-1:0] CNT_STEP  = CNT_W'(4);

  eng_state_t       state;
  logic [AW-1:0]    desc_addr, src, dst;
  logic [31:0]      w0lo;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      desc_addr <= '0;
      last_desc <= '0;
      w0lo      <= '0;
      src       <= '0;
      dst       <= '0;
      remain    <= '0;
      done_irq  <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (state != ST_IDLE && !run) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (run && !pause && !inv_flag) begin
            state     <= ST_F0;
            desc_addr <= next_ptr;
            last_desc <= next_ptr;
          end
          ST_F0: state <= ST_F1;
          ST_F1: begin w0lo <= mem_rdata; state <= ST_F2; end
          ST_F2: state <= ST_F3;
          ST_F3: begin dst <= mem_rdata[AW-1:0]; state <= ST_F4; end
          ST_F4: begin
            src    <= mem_rdata[AW-1:0];
            remain <= w0lo[CNT_W-1:0];
            if (!w0lo[D_VALID])               state <= ST_IDLE;
            else if (w0lo[CNT_W-1:0] == '0)   state <= ST_WB;
            else                              state <= ST_RD;
          end
          ST_RD: state <= ST_WR;
          ST_WR: begin
            src <= src + WORD_STEP;
            dst <= dst + WORD_STEP;
            if (remain <= CNT_STEP) begin
              remain <= '0;
              state  <= ST_WB;
            end else begin
              remain <= remain - CNT_STEP;
              state  <= ST_RD;
            end
          end
          ST_WB: begin
            state    <= ST_IDLE;
            done_irq <= w0lo[D_IRQ];
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign set_inv   = run && (state == ST_F4) && !w0lo[D_VALID];
  assign set_pdone = run && pause && (state == ST_IDLE);
  assign adv       = run && (state == ST_WB);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = mem_rdata;
    case (state)
      ST_F0: mem_req = run;
      ST_F1: begin mem_req = run; mem_addr = desc_addr + AW'(4);  end
      ST_F2: begin mem_req = run; mem_addr = desc_addr + AW'(8);  end
      ST_F3: begin mem_req = run; mem_addr = desc_addr + AW'(12); end
      ST_RD: begin mem_req = run; mem_addr = src; end
      ST_WR: begin mem_req = run; mem_we = run; mem_addr = dst; end
      ST_WB: begin
        mem_req   = run && wb_en;
        mem_we    = run && wb_en;
        mem_wdata = w0lo & ~(32'd1 << D_VALID);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dring_dma.sv
module dring_dma
  import dring_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RING_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              done_irq
);
  ctrl_t             ctrl;
  logic              run, busy, inv_flag, set_inv, set_pdone, adv;
  logic [AW-1:0]     base, next_ptr, last_desc, nxt_adv;
  logic [RING_W-1:0] ring_size;

  assign run = ctrl.start && !ctrl.abort && (ctrl.mode == MODE_RING);

  dring_regs #(.AW(AW), .RING_W(RING_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .last_desc(last_desc), .set_inv(set_inv), .set_pdone(set_pdone),
    .adv(adv), .nxt_adv(nxt_adv), .ctrl(ctrl), .inv_flag(inv_flag),
    .base(base), .next_ptr(next_ptr), .ring_size(ring_size)
  );

  dring_ptr #(.AW(AW), .RING_W(RING_W)) u_ptr (
    .base(base), .ring_size(ring_size), .cur(next_ptr), .nxt(nxt_adv)
  );

  dring_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst(rst), .run(run), .pause(ctrl.pause), .wb_en(ctrl.wb_en),
    .inv_flag(inv_flag), .next_ptr(next_ptr), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .last_desc(last_desc),
    .set_inv(set_inv), .set_pdone(set_pdone), .adv(adv), .done_irq(done_irq)
  );
endmodule

// File: rtl/dring_dma_chk.sv
module dring_dma_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [2:0] reg_sel,
  input logic       wr_abort,
  input logic       wr_start,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] addr_lo,
  input logic       done_irq,
  input logic       busy,
  input logic       inv_flag
);
  // R2: every access is word aligned
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (addr_lo == 2'b00));

  // R8: abort request silences the port next cycle, engine idle after that
  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 3'd0 && wr_abort && !wr_start) |=> (!mem_req ##1 !busy));

  // R7: completion interrupt is a single-cycle pulse
  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R12: a busy period opens with a descriptor read
  assert_fetch_first_R12: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !$past(reg_wr)) |-> (mem_req && !mem_we));

  // R5: while the invalid flag stands the channel stays parked
  assert_parked_idle_R5: assert property (@(posedge clk) disable iff (rst)
    inv_flag |-> !busy);

  // R1: no memory traffic in the first cycle out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !mem_req);
endmodule

bind dring_dma dring_dma_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .wr_abort(reg_wdata[1]), .wr_start(reg_wdata[3]),
  .mem_req(mem_req), .mem_we(mem_we), .addr_lo(mem_addr[1:0]),
  .done_irq(done_irq), .busy(busy), .inv_flag(inv_flag)
);

// File: tb/dring_dma_tb.sv
`timescale 1ns/1ps
module dring_dma_tb;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, done_irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023] = '{default: '0};
  logic        tb_we = 1'b0;
  logic [9:0]  tb_idx = '0;
  logic [31:0] tb_dat = '0;

  int n_chk = 0, n_fail = 0, irq_cnt = 0;
  bit timeout = 0;

  always #2 clk = ~clk;

  dring_dma #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done_irq(done_irq)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_idx] <= tb_dat;
    else if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_req) mem_rdata <= mem[mem_addr[11:2]];
  end

  always @(posedge clk) if (!rst && done_irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mem_put(input int addr, input logic [31:0] val);
    @(negedge clk); tb_we = 1'b1; tb_idx = addr[11:2]; tb_dat = val;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic logic [31:0] mem_get(input int addr);
    return mem[addr[11:2]];
  endfunction

  task automatic put_desc(input int at, input logic [31:0] w0, input int src, input int dst);
    mem_put(at, w0);
    mem_put(at + 4, 32'h0);
    mem_put(at + 8, dst);
    mem_put(at + 12, src);
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [31:0] val);
    @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
    @(negedge clk); reg_rd = 1'b0; val = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 + i * 32'h1111;
  endfunction

  task automatic run_all();
    logic [31:0] v;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    reg_read(3'd0, v); chk("R1 ctrl after reset", v, 32'h0);
    reg_read(3'd4, v); chk("R1 next after reset", v, 32'h0);
    reg_read(3'd5, v); chk("R1 last after reset", v, 32'h0);

    for (int i = 0; i < 4; i++) mem_put(32'h400 + 4 * i, pat(i));
    mem_put(32'h80C, 32'hDEAD_BEEF);
    put_desc(32'h100, 32'hC000_000C, 32'h400, 32'h800);
    reg_write(3'd1, 32'h100);
    reg_write(3'd3, 32'd4);
    reg_write(3'd4, 32'h100);

    // R7 timing: 3 words -> pulse 13 cycles after the start edge
    reg_write(3'd0, 32'h4C);
    cnt = 0;
    while (cnt < 100) begin
      @(negedge clk); cnt++;
      if (done_irq) break;
    end
    chk("R7 done_irq latency", cnt, 32'd13);
    idle(20);
    for (int i = 0; i < 3; i++) chk("R2 copied word", mem_get(32'h800 + 4 * i), pat(i));
    chk("R2 word past count untouched", mem_get(32'h80C), 32'hDEAD_BEEF);
    chk("R3 write-back clears valid", mem_get(32'h100), 32'h4000_000C);
    reg_read(3'd4, v); chk("R4 next advanced", v, 32'h110);
    reg_read(3'd0, v); chk("R5 invalid parks, R12 not busy", v, 32'h14C);
    reg_read(3'd5, v); chk("R5 last is parked entry", v, 32'h110);
    chk("R7 one pulse", irq_cnt, 32'd1);

    // R6 zero count, resume via W1C of bit 8 (R11)
    mem_put(32'h900, 32'h1234_5678);
    put_desc(32'h110, 32'h8000_0000, 32'h400, 32'h900);
    reg_write(3'd0, 32'h14C);
    idle(30);
    chk("R6 zero count written back", mem_get(32'h110), 32'h0);
    chk("R6 zero count moves nothing", mem_get(32'h900), 32'h1234_5678);
    reg_read(3'd4, v); chk("R6 next advanced", v, 32'h120);
    chk("R7 no pulse without enable", irq_cnt, 32'd1);
    reg_read(3'd0, v); chk("R11 refetch then park again", v, 32'h14C);

    // R4 wrap across the last slot
    put_desc(32'h120, 32'h8000_0004, 32'h400, 32'hA00);
    put_desc(32'h130, 32'h8000_0008, 32'h404, 32'hA10);
    reg_write(3'd0, 32'h14C);
    idle(60);
    reg_read(3'd4, v); chk("R4 wrap to base", v, 32'h100);
    reg_read(3'd5, v); chk("R4 last after wrap", v, 32'h100);
    chk("R2 second entry", mem_get(32'hA00), pat(0));
    chk("R2 third entry w0", mem_get(32'hA10), pat(1));
    chk("R2 third entry w1", mem_get(32'hA14), pat(2));

    // R3 write-back disabled
    put_desc(32'h100, 32'h8000_0004, 32'h408, 32'hB00);
    reg_write(3'd0, 32'h148);
    idle(40);
    chk("R3 no write-back when disabled", mem_get(32'h100), 32'h8000_0004);
    chk("R2 copy without write-back", mem_get(32'hB00), pat(2));
    reg_read(3'd4, v); chk("R4 next after no-wb entry", v, 32'h110);

    // R8 abort mid-copy
    put_desc(32'h110, 32'h8000_0040, 32'h400, 32'hC00);
    reg_write(3'd0, 32'h14C);
    idle(10);
    reg_write(3'd0, 32'h46);
    idle(5);
    reg_read(3'd0, v); chk("R8 abort-done set, idle", v, 32'h446);
    reg_read(3'd5, v); chk("R8 last is active entry", v, 32'h110);
    reg_read(3'd4, v); chk("R8 next not advanced", v, 32'h110);
    chk("R8 no write-back on abort", mem_get(32'h110), 32'h8000_0040);

    // R9 restart from rewritten pointer
    mem_put(32'h40C, pat(3));
    put_desc(32'h120, 32'h8000_0004, 32'h40C, 32'hD00);
    reg_write(3'd4, 32'h120);
    reg_write(3'd0, 32'h44C);
    idle(40);
    chk("R9 restarted entry copied", mem_get(32'hD00), pat(3));
    reg_read(3'd4, v); chk("R9 next after restart", v, 32'h130);
    reg_read(3'd0, v); chk("R11 abort-done cleared", v, 32'h14C);

    // R11 mode gating
    put_desc(32'h130, 32'h8000_0004, 32'h400, 32'hE00);
    reg_write(3'd0, 32'h10C);
    idle(20);
    chk("R11 wrong mode fetches nothing", mem_get(32'h130), 32'h8000_0004);
    chk("R11 wrong mode copies nothing", mem_get(32'hE00), 32'h0);
    reg_read(3'd0, v); chk("R11 status with mode 0", v, 32'h00C);

    // R10 pause
    reg_write(3'd0, 32'h4D);
    idle(20);
    reg_read(3'd0, v); chk("R10 pause-done set", v, 32'h24D);
    chk("R10 paused entry not taken", mem_get(32'h130), 32'h8000_0004);
    mem_put(32'h100, 32'h0);
    reg_write(3'd0, 32'h24C);
    idle(40);
    chk("R10 resumes after pause", mem_get(32'hE00), pat(0));
    reg_read(3'd4, v); chk("R10 next after resume", v, 32'h100);
    reg_read(3'd0, v); chk("R11 pause-done cleared", v, 32'h14C);
    chk("R7 total pulses", irq_cnt, 32'd1);
  endtask

  initial begin : main
    fork
      run_all();
      begin repeat (100000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=expired expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule